// File: doc/BRIEF.md
# Configuration Port Access Sequencer

This block lets ordinary logic read and change the 16-bit settings registers of a clock-generation macro. It works without a processor. The macro exposes a small handshake port: an enable, a write flag, a 7-bit register address, 16-bit write data, 16-bit read data and a ready pulse. The sequencer turns a one-cycle command into a correctly paced access on that port. The macro answers after a number of cycles that varies, so the sequencer waits for the ready pulse and does not count a fixed number of cycles.

A command carries an address, write data, a mask, a write flag and a masked-update flag. A plain read or a plain write uses a single port access. A masked update reads the register first, merges the new bits into the old value under the mask, and writes the result back. A watchdog ends any access whose ready pulse does not arrive in time. When that happens the sequencer raises an error flag that stays set and returns to idle. Every command ends with one `rsp_done` pulse.

Top module: `cfgport_master`

## Requirements
- R1: While no command is in progress, `cmd_busy`, `port_en`, `port_we`, `port_addr` and `port_wdata` are all zero.
- R2: A `cmd_start` pulse seen while idle latches the command. One clock later `port_en` is high for exactly one cycle. `port_we` is high in that cycle only for a write access.
- R3: `port_addr` holds the latched address from the enable cycle until the ready cycle. `port_wdata` carries the write value during a write access and is zero during a read access.
- R4: After an enable, no further enable is issued until `port_rdy` has been seen or the watchdog has expired. A `cmd_start` seen while `cmd_busy` is high is ignored and causes no access.
- R5: For a read, `port_rdata` is captured in the cycle `port_rdy` is high. It appears on `rsp_rdata` in the next cycle, together with a `rsp_done` pulse that lasts one cycle. `cmd_busy` is already low in that cycle.
- R6: For a plain write (`cmd_write`=1, `cmd_rmw`=0), `rsp_done` pulses in the cycle after `port_rdy`, and `rsp_rdata` keeps its previous value.
- R7: When `cmd_rmw`=1 the value of `cmd_write` does not matter. The sequencer reads the addressed register, then writes `(old & ~mask) | (new & mask)` to the same address. That write's enable comes in the cycle after the read's ready pulse. `rsp_done` pulses only after the write's ready pulse. `rsp_rdata` then shows the old value.
- R8: If `port_rdy` has not arrived after `TIMEOUT_CYCLES` (default 64) cycles spent waiting, the sequencer goes idle. `rsp_done` pulses in the next cycle and `rsp_err` is set. A masked update whose read times out issues no write.
- R9: `rsp_err` stays set through later successful commands until reset, and reset clears it.
- R10: A `port_rdy` pulse that arrives while the sequencer is idle is ignored: no `rsp_done`, no access, and `rsp_rdata` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all activity is synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_start | input | 1 | One-cycle command request |
| cmd_write | input | 1 | 1 = write, 0 = read (ignored when cmd_rmw is 1) |
| cmd_rmw | input | 1 | 1 = masked read-then-write update |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 16 | Write value, or new bits for a masked update |
| cmd_mask | input | 16 | Bits of cmd_wdata that replace the old value in a masked update |
| cmd_busy | output | 1 | High while an access sequence is active |
| rsp_done | output | 1 | One-cycle completion pulse (success or timeout) |
| rsp_rdata | output | 16 | Last value read from the port |
| rsp_err | output | 1 | Sticky timeout flag |
| port_en | output | 1 | Access enable to the macro |
| port_we | output | 1 | Write select, valid with port_en |
| port_addr | output | 7 | Register address to the macro |
| port_wdata | output | 16 | Write data to the macro |
| port_rdata | input | 16 | Read data from the macro, valid with port_rdy |
| port_rdy | input | 1 | One-cycle ready pulse from the macro |

## Verification
The hardest situations to reach are the timeout paths. They require a responder that does not answer for the whole watchdog window, and this must happen in either half of a masked update. The bench's responder is built into its command tasks. Each access is given its own latency, drawn at random between one and six cycles or set beyond the window on purpose. After a timeout the bench also sends a stray ready pulse while the sequencer is idle. In the middle of a wait it raises a competing start request, to show that both are ignored.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ISSUE = 3'd1,
    ST_RD_WAIT  = 3'd2,
    ST_WR_ISSUE = 3'd3,
    ST_WR_WAIT  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/cfgport_timer.sv
module cfgport_timer #(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // counter is cleared whenever the sequencer is not waiting
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = run ? cnt_q + 1'b1 : '0;
    if (run && cnt_q == LAST) cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/cfgport_datapath.sv
module cfgport_datapath #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_cmd,
  input  logic          cap_rd,
  input  logic          ld_merge,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [DW-1:0] cmd_mask,
  input  logic [DW-1:0] port_rdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] mask_q;
  logic [DW-1:0] merged;

  assign merged = (port_rdata & ~mask_q) | (wdata_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
    end else if (ld_cmd) begin
      addr_q <= cmd_addr;
      mask_q <= cmd_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (ld_cmd)   wdata_q <= cmd_wdata;
    else if (ld_merge) wdata_q <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= port_rdata;
  end
endmodule

// File: rtl/cfgport_fsm.sv
module cfgport_fsm
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic       cmd_write,
  input  logic       cmd_rmw,
  input  logic       port_rdy,
  input  logic       expired,
  output seq_state_e state,
  output logic       ld_cmd,
  output logic       cap_rd,
  output logic       ld_merge,
  output logic       done_q,
  output logic       err_q
);
  seq_state_e state_q, state_d;
  logic       rmw_q;
  logic       finish, abort;

  always_comb begin
    state_d  = state_q;
    ld_cmd   = 1'b0;
    cap_rd   = 1'b0;
    ld_merge = 1'b0;
    finish   = 1'b0;
    abort    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_start) begin
          ld_cmd  = 1'b1;
          state_d = (cmd_rmw || !cmd_write) ? ST_RD_ISSUE : ST_WR_ISSUE;
        end
      end
      ST_RD_ISSUE: state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (port_rdy) begin
          cap_rd = 1'b1;
          if (rmw_q) begin
            ld_merge = 1'b1;
            state_d  = ST_WR_ISSUE;
          end else begin
            finish  = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (expired) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WR_ISSUE: state_d = ST_WR_WAIT;
      ST_WR_WAIT: begin
        if (port_rdy) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end else if (expired) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish | abort;
      if (abort) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rmw_q <= 1'b0;
    else if (ld_cmd) rmw_q <= cmd_rmw;
  end

  assign state = state_q;
endmodule

// File: rtl/cfgport_master.sv
module cfgport_master
  import cfgport_pkg::*;
#(
  parameter int AW             = 7,
  parameter int DW             = 16,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_write,
  input  logic          cmd_rmw,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [DW-1:0] cmd_mask,
  output logic          cmd_busy,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          port_en,
  output logic          port_we,
  output logic [AW-1:0] port_addr,
  output logic [DW-1:0] port_wdata,
  input  logic [DW-1:0] port_rdata,
  input  logic          port_rdy
);
  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  seq_state_e    state;
  logic          ld_cmd, cap_rd, ld_merge, expired, waiting;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  cfgport_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_start(cmd_start),
    .cmd_write(cmd_write),
    .cmd_rmw  (cmd_rmw),
    .port_rdy (port_rdy),
    .expired  (expired),
    .state    (state),
    .ld_cmd   (ld_cmd),
    .cap_rd   (cap_rd),
    .ld_merge (ld_merge),
    .done_q   (rsp_done),
    .err_q    (rsp_err)
  );

  assign waiting = (state == ST_RD_WAIT) || (state == ST_WR_WAIT);

  cfgport_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (waiting),
    .expired(expired)
  );

  cfgport_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ld_cmd    (ld_cmd),
    .cap_rd    (cap_rd),
    .ld_merge  (ld_merge),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_mask  (cmd_mask),
    .port_rdata(port_rdata),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .rdata_q   (rsp_rdata)
  );

  assign cmd_busy   = (state != ST_IDLE);
  assign port_en    = (state == ST_RD_ISSUE) || (state == ST_WR_ISSUE);
  assign port_we    = (state == ST_WR_ISSUE);
  assign port_addr  = cmd_busy ? addr_q : '0;
  assign port_wdata = ((state == ST_WR_ISSUE) || (state == ST_WR_WAIT)) ? wdata_q : '0;
endmodule

// File: rtl/cfgport_master_chk.sv
module cfgport_master_chk #(
  parameter int AW             = 7,
  parameter int DW             = 16,
  parameter int TIMEOUT_CYCLES = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_busy,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic          port_en,
  input logic          port_we,
  input logic [AW-1:0] port_addr,
  input logic [DW-1:0] port_wdata,
  input logic          port_rdy
);
  logic pending_q;
  int   wait_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pending_q <= 1'b0;
    else if (port_en)             pending_q <= 1'b1;
    else if (port_rdy || rsp_done) pending_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                wait_cnt_q <= 0;
    else if (cmd_busy && !port_en && !port_rdy) wait_cnt_q <= wait_cnt_q + 1;
    else                                       wait_cnt_q <= 0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_busy |-> (!port_en && !port_we && port_addr == '0 && port_wdata == '0));

  assert_en_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |=> !port_en);

  assert_we_with_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    port_we |-> port_en);

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && !port_en) |-> ($stable(port_addr) && $stable(port_wdata)));

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |-> !pending_q);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_wait_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt_q <= TIMEOUT_CYCLES);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> rsp_err);

  assert_stray_rdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rdy && !cmd_busy) |=> !rsp_done);
endmodule

bind cfgport_master cfgport_master_chk #(
  .AW(AW), .DW(DW), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_busy  (cmd_busy),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .port_en   (port_en),
  .port_we   (port_we),
  .port_addr (port_addr),
  .port_wdata(port_wdata),
  .port_rdy  (port_rdy)
);

// File: tb/cfgport_master_tb.sv
module cfgport_master_tb;
  localparam int AW  = 7;
  localparam int DW  = 16;
  localparam int TMO = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_start = 1'b0, cmd_write = 1'b0, cmd_rmw = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0, cmd_mask = '0;
  logic          cmd_busy, rsp_done, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic          port_en, port_we;
  logic [AW-1:0] port_addr;
  logic [DW-1:0] port_wdata;
  logic [DW-1:0] port_rdata = '0;
  logic          port_rdy = 1'b0;

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [128];
  logic          exp_err = 1'b0;
  logic [DW-1:0] exp_rdata = '0;
  logic          mon_en = 1'b0;

  always #10 clk = ~clk;

  cfgport_master #(.AW(AW), .DW(DW), .TIMEOUT_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_rmw(cmd_rmw), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask),
    .cmd_busy(cmd_busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .port_en(port_en), .port_we(port_we), .port_addr(port_addr), .port_wdata(port_wdata),
    .port_rdata(port_rdata), .port_rdy(port_rdy)
  );

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1: idle port compared every cycle
  always @(negedge clk) begin
    if (mon_en && !cmd_busy) begin
      chk_eq("R1 idle enable", port_en, 0);
      chk_eq("R1 idle write flag", port_we, 0);
      chk_eq("R1 idle address", port_addr, 0);
      chk_eq("R1 idle data", port_wdata, 0);
    end
  end

  task automatic phase(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] di,
                       input int lat, input bit inj, output bit to);
    int lim;
    to  = (lat > TMO);
    lim = to ? TMO : lat;
    chk_eq("R2 enable in issue cycle", port_en, 1);
    chk_eq("R2 write flag", port_we, we);
    chk_eq("R3 address at issue", port_addr, a);
    chk_eq("R3 data at issue", port_wdata, we ? di : '0);
    chk_eq("R4 busy during access", cmd_busy, 1);
    chk_eq("R5 done low during access", rsp_done, 0);
    @(negedge clk);
    for (int k = 0; k < lim; k++) begin
      chk_eq("R4 no enable while waiting", port_en, 0);
      chk_eq("R3 address held", port_addr, a);
      chk_eq("R3 data held", port_wdata, we ? di : '0);
      chk_eq("R4 busy while waiting", cmd_busy, 1);
      if (inj && k == 0) begin
        cmd_start = 1'b1; cmd_addr = ~a; cmd_write = ~we; cmd_wdata = 16'($urandom);
      end
      if (!to && k == lat - 1) begin
        port_rdy   = 1'b1;
        port_rdata = we ? 16'($urandom) : mem[a];
      end
      @(negedge clk);
      port_rdy = 1'b0; cmd_start = 1'b0; port_rdata = 16'($urandom);
    end
  endtask

  task automatic end_chk(input string tag);
    chk_eq({tag, " done pulse"}, rsp_done, 1);
    chk_eq({tag, " busy released"}, cmd_busy, 0);
    chk_eq({tag, " read data"}, rsp_rdata, exp_rdata);
    chk_eq({tag, " error flag"}, rsp_err, exp_err);
  endtask

  task automatic run_cmd(input bit wr, input bit rmw, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [DW-1:0] m,
                         input int lat1, input int lat2, input bit inj);
    bit to;
    logic [DW-1:0] old, merged;
    cmd_start = 1'b1; cmd_write = wr; cmd_rmw = rmw; cmd_addr = a; cmd_wdata = d; cmd_mask = m;
    @(negedge clk);
    cmd_start = 1'b0; cmd_write = 1'($urandom); cmd_rmw = 1'($urandom);
    cmd_addr = 7'($urandom); cmd_wdata = 16'($urandom); cmd_mask = 16'($urandom);
    if (rmw || !wr) begin
      old = mem[a];
      phase(1'b0, a, '0, lat1, inj, to);
      if (to) begin exp_err = 1'b1; end_chk("R8 read timeout"); return; end
      exp_rdata = old;
      if (!rmw) begin end_chk("R5 read"); return; end
      merged = (old & ~m) | (d & m);
      phase(1'b1, a, merged, lat2, 1'b0, to);
      if (to) begin exp_err = 1'b1; end_chk("R8 update write timeout"); return; end
      mem[a] = merged;
      end_chk("R7 masked update");
    end else begin
      phase(1'b1, a, d, lat1, inj, to);
      if (to) begin exp_err = 1'b1; end_chk("R8 write timeout"); return; end
      mem[a] = d;
      end_chk("R6 write");
    end
  endtask

  task automatic idle_cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_eq({tag, " no enable"}, port_en, 0);
      chk_eq({tag, " not busy"}, cmd_busy, 0);
      chk_eq({tag, " no done"}, rsp_done, 0);
      chk_eq({tag, " read data kept"}, rsp_rdata, exp_rdata);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
    repeat (3) @(negedge clk);
    // reset state
    chk_eq("R1 reset busy", cmd_busy, 0);
    chk_eq("R1 reset enable", port_en, 0);
    chk_eq("R9 reset error", rsp_err, 0);
    chk_eq("R5 reset done", rsp_done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // plain writes and reads at boundary addresses, several latencies
    run_cmd(1, 0, 7'd0,   16'hA5A5, 16'h0, 1, 0, 0);
    run_cmd(1, 0, 7'd127, 16'hFFFF, 16'h0, 4, 0, 0);
    run_cmd(0, 0, 7'd0,   16'h0,    16'h0, 2, 0, 0);
    run_cmd(0, 0, 7'd127, 16'h0,    16'h0, 6, 0, 0);
    run_cmd(0, 0, 7'd33,  16'h0,    16'h0, 1, 0, 0);
    idle_cycles(2, "R6 gap");

    // masked updates: partial, empty, full mask; write flag set with rmw (R7)
    run_cmd(0, 1, 7'd10, 16'h1234, 16'h00FF, 3, 2, 0);
    run_cmd(1, 1, 7'd11, 16'hBEEF, 16'h0000, 1, 1, 0);
    run_cmd(1, 1, 7'd12, 16'hC0DE, 16'hFFFF, 5, 3, 0);
    run_cmd(0, 0, 7'd10, 16'h0,    16'h0,    2, 0, 0);

    // start during wait is ignored (R4)
    run_cmd(0, 0, 7'd20, 16'h0, 16'h0, 5, 0, 1);
    idle_cycles(3, "R4 ignored start");
    run_cmd(1, 0, 7'd21, 16'h7777, 16'h0, 3, 0, 1);
    idle_cycles(3, "R4 ignored start");

    // read timeout, then stray ready while idle (R8, R10)
    run_cmd(0, 0, 7'd40, 16'h0, 16'h0, TMO + 10, 0, 0);
    port_rdy = 1'b1; port_rdata = 16'hDEAD;
    @(negedge clk);
    port_rdy = 1'b0;
    chk_eq("R10 stray ready no done", rsp_done, 0);
    chk_eq("R10 stray ready not busy", cmd_busy, 0);
    chk_eq("R10 stray ready data kept", rsp_rdata, exp_rdata);
    idle_cycles(2, "R10 after stray ready");

    // masked update whose read times out issues no write; another whose write times out
    run_cmd(0, 1, 7'd41, 16'hFFFF, 16'hFFFF, TMO + 1, 1, 0);
    idle_cycles(2, "R8 aborted update");
    run_cmd(0, 0, 7'd41, 16'h0, 16'h0, 1, 0, 0);
    run_cmd(0, 1, 7'd42, 16'h0F0F, 16'hF0F0, 2, TMO + 5, 0);
    // write timeout: register unchanged in model
    run_cmd(1, 0, 7'd43, 16'h1111, 16'h0, TMO + 3, 0, 0);

    // error flag sticky across good commands (R9)
    run_cmd(1, 0, 7'd44, 16'h2222, 16'h0, 2, 0, 0);
    chk_eq("R9 error still set", rsp_err, 1);

    // back-to-back random traffic
    for (int n = 0; n < 40; n++) begin
      run_cmd(1'($urandom), ($urandom % 4) == 0, 7'($urandom), 16'($urandom),
              16'($urandom), 1 + int'($urandom % 6), 1 + int'($urandom % 6), 0);
    end
    chk_eq("R9 error still set after traffic", rsp_err, 1);

    // reset clears the error (R9)
    mon_en = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    chk_eq("R9 reset clears error", rsp_err, 0);
    chk_eq("R1 reset busy low", cmd_busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_en = 1'b1;
    exp_err = 1'b0; exp_rdata = '0;
    run_cmd(0, 0, 7'd5, 16'h0, 16'h0, 2, 0, 0);
    idle_cycles(2, "R9 after reset");

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule